// File: doc/BRIEF.md
# Programmable Rotating-Priority Interrupt Controller

This block gathers eight interrupt lines and presents one interrupt request to a processor. Each line's rising edge is latched into a request register. The block also keeps an in-service register and a mask register. A priority resolver chooses the winning level. Priority is either fixed, with level 0 highest after reset or initialization, or rotating: a command or an automatic end-of-interrupt can move the lowest-priority position. When the processor pulses `ack`, the block returns an 8-bit vector the following cycle. The vector is a programmed base in bits 7-3 with the winning level in bits 2-0.

Software reaches the block through two addresses (`addr` = 0 is the even address, `addr` = 1 is the odd address), with a write strobe, a read strobe and an 8-bit data bus.

- **Initialization.** An even write with data bit 4 set starts a three-write sequence on the odd address. The initialization sequencer walks the states `SEQ_RUN` → `SEQ_BASE` → `SEQ_CASC` → `SEQ_MODE` → `SEQ_RUN`. The transitions are:
  - *start*: an even write with bit 4 set, taken from any state.
  - *base taken*: the first odd write, in `SEQ_BASE`.
  - *cascade skipped*: the second odd write, in `SEQ_CASC`.
  - *mode taken*: the third odd write, in `SEQ_MODE`.
  - *mask write*: an odd write in `SEQ_RUN`, which keeps the sequencer in `SEQ_RUN`.
- **Even-address commands.** With bits 4-3 = 00, the write is an end-of-interrupt or priority command. With bits 4-3 = 01 and bit 7 = 0, the write is a mode command that sets special mask mode, poll and the readback selection.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_out` and `vector_valid` are 0. Reads of both addresses return 0, and level 0 has the highest priority.
- R2: A rising edge on `irq_in[n]` sets request bit n one cycle later. Outside poll, an even read returns the request register until the readback selection is changed.
- R3: An odd write in `SEQ_RUN` loads the mask; bit n = 0 enables level n. An odd read returns the mask. A masked request never raises `int_out`.
- R4: An even write with bit 4 = 1 does the following:
  - It clears the mask and the in-service register, and makes level 0 highest.
  - It selects request readback, and clears special mask mode, poll, the rotate-on-auto-EOI flag, auto-EOI and special fully-nested mode.
  - The next three odd writes are then taken as the base (bits 7-3), the cascade word (ignored) and the mode word.
- R5: A one-cycle `ack` makes `vector_valid` high for exactly the next cycle, with `vector` = {base, winning level}. On the same edge, the winner's in-service bit is set and its request bit is cleared. With no pending unmasked request, the vector carries level 7.
- R6: `int_out` is high only when the highest-priority unmasked request outranks every in-service level.
- R7: End-of-interrupt command codes (bits 7-5 of an even write with bits 4-3 = 00; bits 2-0 name the level):
  - 001: clears the highest-priority in-service bit.
  - 011: clears in-service bit L.
  - 010: changes nothing.
- R8: Rotation commands make a level the lowest priority:
  - 101: acts as 001 and then makes the cleared level lowest.
  - 111: acts as 011 and then makes L lowest.
  - 110: makes L lowest and leaves the in-service register unchanged.
- R9: Mode-word bit 1 = 1 selects auto-EOI, and no in-service bit is kept after an acknowledge. Command 100 sets the rotate-on-auto-EOI flag and command 000 clears it. While the flag is set, each automatically ended level becomes the lowest priority.
- R10: Bits 1-0 of a mode command select the readback: 10 selects the request register and 11 selects the in-service register. The values 00 and 01 leave the selection unchanged.
- R11: Bits 6-5 of a mode command control special mask mode: 11 enters it and 10 leaves it. While it is active, any unmasked request that is not in service raises `int_out`, whatever its priority.
- R12: A mode command with bit 2 = 1 arms a poll. The next even read then returns {1, 0000, level} for the winning request, or 0 when none is pending. That read acts as an acknowledge for the polled level, and the poll then ends.
- R13: Mode-word bit 4 = 1 selects special fully-nested mode. In this mode, a request at the same level as the highest in-service level raises `int_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Interrupt lines, rising-edge sensitive |
| addr | input | 1 | Register address: 0 = even, 1 = odd |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe; side effects occur at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the current state |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse |
| vector | output | 8 | Vector returned after an acknowledge |
| vector_valid | output | 1 | High for one cycle when `vector` is valid |

## Verification
- **Interrupt lines.** A rising edge on `irq_in` shows in the request register, and therefore on `int_out`, after one clock edge. The bench raises a line at a falling edge and samples at the next falling edge.
- **Register writes.** Every register write, command and acknowledge takes effect on the edge that ends its one-cycle strobe. `vector` and `vector_valid` are registered on that same edge, so the bench checks them at the falling edge straight after dropping `ack`.
- **Reads.** `rdata` is combinational and is sampled while `rd_en` is high, before the edge that applies any poll side effect.
- **Priority sweep.** The sweep programs each of the eight lowest-priority positions and drains several request patterns one acknowledge at a time. The expected order is computed arithmetically as (lowest + k) mod 8.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int DATA_W  = 8;

    typedef enum logic [1:0] {
        SEQ_RUN,
        SEQ_BASE,
        SEQ_CASC,
        SEQ_MODE
    } seq_state_t;

    // even-address command selectors (data bits 4-3)
    localparam logic [1:0] SEL_EOI  = 2'b00;
    localparam logic [1:0] SEL_MODE = 2'b01;

    // end-of-interrupt / priority actions (data bits 7-5)
    localparam logic [2:0] ACT_ROT_AUTO_CLR = 3'b000;
    localparam logic [2:0] ACT_EOI_ANY      = 3'b001;
    localparam logic [2:0] ACT_NOP          = 3'b010;
    localparam logic [2:0] ACT_EOI_ONE      = 3'b011;
    localparam logic [2:0] ACT_ROT_AUTO_SET = 3'b100;
    localparam logic [2:0] ACT_ROT_ANY      = 3'b101;
    localparam logic [2:0] ACT_SET_LOW      = 3'b110;
    localparam logic [2:0] ACT_ROT_ONE      = 3'b111;

    // mode word bit positions
    localparam int MW_AUTO_EOI = 1;
    localparam int MW_NESTED   = 4;

endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] low,
    output logic         hit,
    output logic [W-1:0] lvl
);

    logic [N-1:0] rot;

    // rot[k] is the request k+1 places above the lowest-priority level
    for (genvar k = 0; k < N; k++) begin : g_rot
        logic [W-1:0] idx;
        assign idx    = low + W'(k + 1);
        assign rot[k] = req[idx];
    end

    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (rot[k]) begin
                hit = 1'b1;
                lvl = low + W'(k + 1);
            end
        end
    end

endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic odd_wr,
    output logic load_base,
    output logic load_mode,
    output logic load_mask,
    output logic in_run
);

    seq_state_t state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_RUN;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n   = state_q;
        load_base = 1'b0;
        load_mode = 1'b0;
        load_mask = 1'b0;
        in_run    = (state_q == SEQ_RUN);
        unique case (state_q)
            SEQ_RUN: begin
                if (odd_wr) load_mask = 1'b1;
            end
            SEQ_BASE: begin
                if (odd_wr) begin
                    load_base = 1'b1;
                    state_n   = SEQ_CASC;
                end
            end
            SEQ_CASC: begin
                if (odd_wr) state_n = SEQ_MODE;
            end
            SEQ_MODE: begin
                if (odd_wr) begin
                    load_mode = 1'b1;
                    state_n   = SEQ_RUN;
                end
            end
        endcase
        if (start) begin
            state_n   = SEQ_BASE;
            load_mask = 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NL = NUM_LVL,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] irq_in,
    input  logic          addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          int_out,
    input  logic          ack,
    output logic [DW-1:0] vector,
    output logic          vector_valid
);

    localparam int LW = $clog2(NL);
    localparam int BW = DW - LW;

    logic [NL-1:0] irq_q, irr_q, isr_q, imr_q;
    logic [NL-1:0] irr_n, isr_n, imr_n;
    logic [LW-1:0] low_q, low_n;
    logic [BW-1:0] base_q, base_n;
    logic          aeoi_q, aeoi_n, sfnm_q, sfnm_n, rotae_q, rotae_n;
    logic          smm_q, smm_n, poll_q, poll_n, sel_isr_q, sel_isr_n;
    logic [DW-1:0] vec_q;
    logic          vval_q;

    // strobes
    logic wr_even, wr_odd, cmd_init, cmd_eoi, cmd_mode, poll_rd, take;
    assign wr_even  = wr_en && !addr;
    assign wr_odd   = wr_en && addr;
    assign cmd_init = wr_even && wdata[4];
    assign cmd_eoi  = wr_even && (wdata[4:3] == SEL_EOI);
    assign cmd_mode = wr_even && (wdata[4:3] == SEL_MODE) && !wdata[7];
    assign poll_rd  = rd_en && !addr && poll_q;
    assign take     = ack || poll_rd;

    logic load_base, load_mode, load_mask, seq_run;

    irq_init_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cmd_init),
        .odd_wr    (wr_odd),
        .load_base (load_base),
        .load_mode (load_mode),
        .load_mask (load_mask),
        .in_run    (seq_run)
    );

    // priority resolution
    logic [NL-1:0] cand;
    logic          req_hit, isr_hit;
    logic [LW-1:0] req_lvl, isr_lvl, rank_r, rank_s, ack_lvl;

    assign cand = smm_q ? (irr_q & ~imr_q & ~isr_q) : (irr_q & ~imr_q);

    irq_prio_resolver #(.N(NL), .W(LW)) u_req_res (
        .req (cand),
        .low (low_q),
        .hit (req_hit),
        .lvl (req_lvl)
    );

    irq_prio_resolver #(.N(NL), .W(LW)) u_isr_res (
        .req (isr_q),
        .low (low_q),
        .hit (isr_hit),
        .lvl (isr_lvl)
    );

    // rank 0 is the highest priority
    assign rank_r  = req_lvl - low_q - LW'(1);
    assign rank_s  = isr_lvl - low_q - LW'(1);
    assign ack_lvl = req_hit ? req_lvl : '1;

    always_comb begin
        int_out = 1'b0;
        if (req_hit) begin
            if (smm_q || !isr_hit || (rank_r < rank_s) || (sfnm_q && rank_r == rank_s))
                int_out = 1'b1;
        end
    end

    // next state
    always_comb begin
        irr_n     = irr_q;
        isr_n     = isr_q;
        imr_n     = imr_q;
        low_n     = low_q;
        base_n    = base_q;
        aeoi_n    = aeoi_q;
        sfnm_n    = sfnm_q;
        rotae_n   = rotae_q;
        smm_n     = smm_q;
        poll_n    = poll_q;
        sel_isr_n = sel_isr_q;

        if (take && req_hit) begin
            irr_n[req_lvl] = 1'b0;
            if (!aeoi_q)      isr_n[req_lvl] = 1'b1;
            else if (rotae_q) low_n = req_lvl;
        end
        if (poll_rd) poll_n = 1'b0;

        if (cmd_eoi) begin
            unique case (wdata[7:5])
                ACT_ROT_AUTO_CLR: rotae_n = 1'b0;
                ACT_EOI_ANY:      if (isr_hit) isr_n[isr_lvl] = 1'b0;
                ACT_NOP:          ;
                ACT_EOI_ONE:      isr_n[wdata[LW-1:0]] = 1'b0;
                ACT_ROT_AUTO_SET: rotae_n = 1'b1;
                ACT_ROT_ANY: begin
                    if (isr_hit) begin
                        isr_n[isr_lvl] = 1'b0;
                        low_n          = isr_lvl;
                    end
                end
                ACT_SET_LOW:      low_n = wdata[LW-1:0];
                ACT_ROT_ONE: begin
                    isr_n[wdata[LW-1:0]] = 1'b0;
                    low_n                = wdata[LW-1:0];
                end
            endcase
        end

        if (cmd_mode) begin
            if (wdata[6:5] == 2'b11) smm_n = 1'b1;
            if (wdata[6:5] == 2'b10) smm_n = 1'b0;
            if (wdata[2])            poll_n = 1'b1;
            if (wdata[1:0] == 2'b10) sel_isr_n = 1'b0;
            if (wdata[1:0] == 2'b11) sel_isr_n = 1'b1;
        end

        if (cmd_init) begin
            imr_n     = '0;
            isr_n     = '0;
            low_n     = '1;
            sel_isr_n = 1'b0;
            smm_n     = 1'b0;
            poll_n    = 1'b0;
            rotae_n   = 1'b0;
            aeoi_n    = 1'b0;
            sfnm_n    = 1'b0;
        end

        if (load_mask) imr_n  = wdata[NL-1:0];
        if (load_base) base_n = wdata[DW-1:LW];
        if (load_mode) begin
            aeoi_n = wdata[MW_AUTO_EOI];
            sfnm_n = wdata[MW_NESTED];
        end

        irr_n = irr_n | (irq_in & ~irq_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q     <= '0;
            irr_q     <= '0;
            isr_q     <= '0;
            imr_q     <= '0;
            low_q     <= '1;
            base_q    <= '0;
            aeoi_q    <= 1'b0;
            sfnm_q    <= 1'b0;
            rotae_q   <= 1'b0;
            smm_q     <= 1'b0;
            poll_q    <= 1'b0;
            sel_isr_q <= 1'b0;
            vec_q     <= '0;
            vval_q    <= 1'b0;
        end else begin
            irq_q     <= irq_in;
            irr_q     <= irr_n;
            isr_q     <= isr_n;
            imr_q     <= imr_n;
            low_q     <= low_n;
            base_q    <= base_n;
            aeoi_q    <= aeoi_n;
            sfnm_q    <= sfnm_n;
            rotae_q   <= rotae_n;
            smm_q     <= smm_n;
            poll_q    <= poll_n;
            sel_isr_q <= sel_isr_n;
            vval_q    <= ack;
            if (ack) vec_q <= {base_q, ack_lvl};
        end
    end

    assign vector       = vec_q;
    assign vector_valid = vval_q;

    always_comb begin
        if (addr)        rdata = DW'(imr_q);
        else if (poll_q) rdata = {req_hit, {(DW - 1 - LW){1'b0}}, req_lvl};
        else if (sel_isr_q) rdata = DW'(isr_q);
        else             rdata = DW'(irr_q);
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NL = 8,
    parameter int DW = 8,
    parameter int BW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          ack,
    input logic          int_out,
    input logic          vector_valid,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] vector,
    input logic [NL-1:0] irr_q,
    input logic [NL-1:0] isr_q,
    input logic [NL-1:0] imr_q,
    input logic [BW-1:0] base_q,
    input logic          poll_q,
    input logic          seq_run
);

    assert_int_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (|(irr_q & ~imr_q)));

    assert_vec_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vector_valid);

    assert_vec_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vector_valid);

    assert_vec_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_en) |=> (vector[DW-1:DW-BW] == $past(base_q)));

    assert_init_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (imr_q == '0 && isr_q == '0));

    assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_run) |=> (imr_q == $past(wdata[NL-1:0])));

    assert_poll_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && poll_q && !wr_en) |=> !poll_q);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NL(NL), .DW(DW), .BW(BW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .ack          (ack),
    .int_out      (int_out),
    .vector_valid (vector_valid),
    .wdata        (wdata),
    .vector       (vector),
    .irr_q        (irr_q),
    .isr_q        (isr_q),
    .imr_q        (imr_q),
    .base_q       (base_q),
    .poll_q       (poll_q),
    .seq_run      (seq_run)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       addr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       int_out;
    logic       ack = 1'b0;
    logic [7:0] vector;
    logic       vector_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .int_out(int_out),
        .ack(ack), .vector(vector), .vector_valid(vector_valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk); irq_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack(input string req, input logic [7:0] exp);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        check({req, " valid"}, {7'd0, vector_valid}, 8'h01);
        check({req, " vector"}, vector, exp);
        @(negedge clk);
        check({req, " valid drop"}, {7'd0, vector_valid}, 8'h00);
    endtask

    task automatic init(input logic [7:0] b, input logic [7:0] c, input logic [7:0] m);
        wr(1'b0, 8'h10); wr(1'b1, b); wr(1'b1, c); wr(1'b1, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 int_out", {7'd0, int_out}, 8'h00);
        check("R1 valid", {7'd0, vector_valid}, 8'h00);
        rd(1'b0, d); check("R1 even read", d, 8'h00);
        rd(1'b1, d); check("R1 odd read", d, 8'h00);

        init(8'h48, 8'h00, 8'h00);
        set_irq(8'h08);
        rd(1'b0, d); check("R2 request latched", d, 8'h08);
        check("R6 int raised", {7'd0, int_out}, 8'h01);

        // R3 mask
        wr(1'b1, 8'h08);
        rd(1'b1, d); check("R3 mask readback", d, 8'h08);
        check("R3 masked int", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h00);
        check("R3 unmasked int", {7'd0, int_out}, 8'h01);

        do_ack("R5 ack lvl3", 8'h4B);
        rd(1'b0, d); check("R5 request cleared", d, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); check("R10 isr select", d, 8'h08);
        check("R5 int low after ack", {7'd0, int_out}, 8'h00);

        // R6 nesting
        set_irq(8'h28);
        check("R6 lower level blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h2A);
        check("R6 higher level passes", {7'd0, int_out}, 8'h01);
        do_ack("R6 ack lvl1", 8'h49);
        wr(1'b0, 8'h08);
        rd(1'b0, d); check("R10 select unchanged", d, 8'h0A);

        // R7 eoi
        wr(1'b0, 8'h20);
        rd(1'b0, d); check("R7 nonspecific eoi", d, 8'h08);
        wr(1'b0, 8'h40);
        rd(1'b0, d); check("R7 no action", d, 8'h08);
        wr(1'b0, 8'h63);
        rd(1'b0, d); check("R7 specific eoi", d, 8'h00);
        check("R6 pending lvl5 raises", {7'd0, int_out}, 8'h01);
        do_ack("R5 ack lvl5", 8'h4D);
        wr(1'b0, 8'h65);
        set_irq(8'h00);
        do_ack("R5 spurious", 8'h4F);

        // R11 special mask mode
        set_irq(8'h04);
        do_ack("R11 ack lvl2", 8'h4A);
        set_irq(8'h44);
        check("R6 lvl6 blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h68);
        check("R11 smm passes", {7'd0, int_out}, 8'h01);
        wr(1'b0, 8'h48);
        check("R11 smm left", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h62);
        do_ack("R11 ack lvl6", 8'h4E);
        wr(1'b0, 8'h66);
        set_irq(8'h00);

        // R8 rotation
        wr(1'b0, 8'hC4);
        set_irq(8'h81);
        do_ack("R8 set priority winner", 8'h4F);
        wr(1'b0, 8'hA0);
        do_ack("R8 rotate nonspecific", 8'h48);
        wr(1'b0, 8'hE0);
        rd(1'b0, d); check("R8 rotate specific clears", d, 8'h00);
        set_irq(8'h00);
        set_irq(8'h03);
        do_ack("R8 rotated order", 8'h49);
        wr(1'b0, 8'h61);
        do_ack("R8 rotated order 2", 8'h48);
        wr(1'b0, 8'h60);
        set_irq(8'h00);

        // R8 R6 sweep over all lowest positions and several patterns
        for (int pr = 0; pr < 8; pr++) begin
            for (int pi = 0; pi < 6; pi++) begin
                logic [7:0] pat;
                pat = 8'((pi * 53 + 29) & 255) | 8'(1 << pi);
                wr(1'b0, 8'hC0 | 8'(pr));
                set_irq(pat);
                for (int n = 0; n < 8; n++) begin
                    if (pat != 8'h00) begin
                        int lv;
                        lv = -1;
                        for (int k = 1; k <= 8; k++)
                            if (lv < 0 && pat[(pr + k) % 8]) lv = (pr + k) % 8;
                        do_ack("R8 sweep", 8'h48 | 8'(lv));
                        wr(1'b0, 8'h60 | 8'(lv));
                        pat[lv] = 1'b0;
                    end
                end
                set_irq(8'h00);
            end
        end
        wr(1'b0, 8'hC7);

        // R4 init, R9 auto-eoi
        wr(1'b1, 8'hF0);
        init(8'h80, 8'hF8, 8'h02);
        rd(1'b1, d); check("R4 mask cleared", d, 8'h00);
        set_irq(8'h04);
        rd(1'b0, d); check("R4 request readback", d, 8'h04);
        do_ack("R4 R9 base kept", 8'h82);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); check("R9 no in-service", d, 8'h00);
        set_irq(8'h00);
        wr(1'b0, 8'h80);
        set_irq(8'h0A);
        do_ack("R9 rotate ack1", 8'h81);
        set_irq(8'h0B);
        do_ack("R9 rotate ack3", 8'h83);
        do_ack("R9 rotate ack0", 8'h80);
        wr(1'b0, 8'h00);
        set_irq(8'h00);
        set_irq(8'h50);
        do_ack("R9 no rotate ack4", 8'h84);
        set_irq(8'h54);
        do_ack("R9 no rotate ack2", 8'h82);
        do_ack("R9 no rotate ack6", 8'h86);
        rd(1'b0, d); check("R9 in-service stays empty", d, 8'h00);
        set_irq(8'h00);

        // R13 special fully nested
        init(8'h00, 8'h00, 8'h10);
        set_irq(8'h08);
        do_ack("R13 ack lvl3", 8'h03);
        set_irq(8'h00);
        set_irq(8'h08);
        check("R13 same level passes", {7'd0, int_out}, 8'h01);
        wr(1'b0, 8'h63);
        do_ack("R13 ack again", 8'h03);
        wr(1'b0, 8'h63);
        set_irq(8'h00);

        // R12 poll
        init(8'h00, 8'h00, 8'h00);
        set_irq(8'h40);
        wr(1'b0, 8'h0F);
        rd(1'b0, d); check("R12 poll word", d, 8'h86);
        rd(1'b0, d); check("R12 poll once, acts as ack", d, 8'h40);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); check("R12 request cleared", d, 8'h00);
        wr(1'b0, 8'h66);
        set_irq(8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); check("R12 poll none", d, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule